// File: doc/BRIEF.md
# Configuration Port Target Responder

This block stands in for the target device on a serial configuration port, so that a configuration sequencer can be run against something that answers like the real device. It is an SPI responder in mode 0. It shifts in command frames while chip select is low, decodes the first byte of each frame as an opcode, and keeps a 32-bit status word that a read-status frame returns in the same chip-select window.

The responder models only the behaviour the sequencer depends on: the status flags, the error code, timed busy periods after erase and after program-done, a count of accepted program pages, and a refresh that can be made to fail a set number of times so that a retry loop gets exercised. It does not store the image contents.

The SPI inputs are taken to be synchronous to `clk` and much slower than it. The responder samples MOSI on each SCLK rising edge. It updates MISO a few `clk` cycles after that edge, so the controller sees a new bit when it next samples on a rising edge.

Top module: `cfg_target_resp`

## Requirements
- R1: Bits are taken MSB first on SCLK rising edges while cs_n is low. A frame ends when cs_n rises. Only whole bytes count, and a frame of fewer than 4 bytes has no effect on status or page count.
- R2: The status word has BUSY at bit 12, FAIL at bit 13, ENABLED at bit 9, DONE at bit 8 and the error code at bits 25:23, with all other bits zero. It is zero after reset. When the first byte of a frame is 0x3C, the 32 bits after the 4th byte carry the status word MSB first, and the frame itself changes nothing.
- R3: Opcode 0xC6 sets ENABLED, clears FAIL and sets the error code to 0 (none).
- R4: Opcode 0x0E clears DONE, resets the page count to 0 and holds BUSY for ERASE_BUSY_CLKS clock cycles.
- R5: A frame with opcode 0x70 and exactly 4+PAGE_BYTES bytes adds one to the page count. A frame with opcode 0x70 and any other byte count of 4 or more leaves the count unchanged and sets the error code to 6 (overflow).
- R6: Opcode 0x5E clears DONE and holds BUSY for DONE_BUSY_CLKS cycles. When BUSY ends, DONE is set if the page count is non-zero, and FAIL is set otherwise.
- R7: Opcode 0x46 leaves the status unchanged. Any opcode not listed in R2 to R8 sets the error code to 2 (command error).
- R8: Opcode 0x79 clears ENABLED and keeps DONE. The first REFRESH_ERR_COUNT refreshes after reset set the error code to 3 (CRC), and every later refresh sets it to 0.
- R9: BUSY and DONE are never set together, and DONE only rises in the cycle in which BUSY falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sclk | input | 1 | SPI serial clock, mode 0 |
| cs_n | input | 1 | SPI chip select, active low |
| mosi | input | 1 | Serial data from the controller |
| miso | output | 1 | Serial data to the controller, status word during a read |
| page_count | output | PAGE_CNT_W | Number of accepted program pages since the last erase |

## Verification
The hardest states to reach are the ones that depend on timing and history rather than on the last command. One is a status read that lands inside a busy window. Another is a program-done issued when no page has been accepted. A third is a refresh whose error depends on how many refreshes came before it. The stimulus reaches the busy window by issuing a read-status frame right after erase or program-done, since that frame is shorter than either busy period. It then waits out the window and reads again. It reaches the no-page case by issuing program-done right after an erase. It issues three refreshes in a row to cross the REFRESH_ERR_COUNT boundary. Malformed frames (a short program page and a 2-byte frame) are each followed by a status read and a page-count check to show what changed and what did not.

// File: rtl/cfg_resp_pkg.sv
// Package: opcodes, status bit positions, error codes and decoded command kinds
// shared by the configuration target responder modules.
package cfg_resp_pkg;

    localparam logic [7:0] OPC_ENABLE   = 8'hC6;
    localparam logic [7:0] OPC_ERASE    = 8'h0E;
    localparam logic [7:0] OPC_INITADDR = 8'h46;
    localparam logic [7:0] OPC_PROGPAGE = 8'h70;
    localparam logic [7:0] OPC_PROGDONE = 8'h5E;
    localparam logic [7:0] OPC_RDSTAT   = 8'h3C;
    localparam logic [7:0] OPC_REFRESH  = 8'h79;

    localparam int STAT_W      = 32;
    localparam int BIT_BUSY    = 12;
    localparam int BIT_FAIL    = 13;
    localparam int BIT_ENAB    = 9;
    localparam int BIT_DONE    = 8;
    localparam int BIT_ERR_LSB = 23;

    typedef enum logic [2:0] {
        ERR_NONE     = 3'd0,
        ERR_ID       = 3'd1,
        ERR_CMD      = 3'd2,
        ERR_CRC      = 3'd3,
        ERR_PREAMBLE = 3'd4,
        ERR_ABORT    = 3'd5,
        ERR_OVERFLOW = 3'd6,
        ERR_EOF      = 3'd7
    } err_code_e;

    typedef enum logic [2:0] {
        CMD_NONE,
        CMD_ENABLE,
        CMD_ERASE,
        CMD_INIT,
        CMD_PROGDONE,
        CMD_REFRESH,
        CMD_BAD
    } cmd_e;

    typedef struct packed {
        logic      busy;
        logic      fail;
        logic      enab;
        logic      done;
        err_code_e err;
    } flags_t;

endpackage

// File: rtl/cfg_spi_shifter.sv
// SPI mode-0 shifter for the responder.
// Assumes sclk, cs_n and mosi are synchronous to clk and far slower than it.
// Receives bytes MSB first on SCLK rising edges. Transmits a loaded word MSB
// first: the word is shifted one place after each rising edge, so a bit stays
// on MISO until the controller has sampled it.
module cfg_spi_shifter #(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk,
    input  logic              cs_n,
    input  logic              mosi,
    input  logic              load_en,
    input  logic [WORD_W-1:0] load_word,
    output logic              byte_valid,
    output logic [7:0]        byte_data,
    output logic              frame_end,
    output logic              miso
);
    localparam int BIT_CNT_W = 3;

    logic                 sclk_q;
    logic                 cs_q;
    logic [BIT_CNT_W-1:0] bit_cnt;
    logic [7:0]           rx_sr;
    logic [WORD_W-1:0]    tx_sr;
    logic                 sclk_rise;

    assign sclk_rise = sclk & ~sclk_q & ~cs_n;
    assign frame_end = cs_n & ~cs_q;
    assign byte_data = rx_sr;
    assign miso      = tx_sr[WORD_W-1];

    // Purpose: edge history, receive shift register and byte strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_q     <= 1'b0;
            cs_q       <= 1'b1;
            bit_cnt    <= '0;
            rx_sr      <= '0;
            byte_valid <= 1'b0;
        end else begin
            sclk_q     <= sclk;
            cs_q       <= cs_n;
            byte_valid <= 1'b0;
            if (cs_n) begin
                bit_cnt <= '0;
            end else if (sclk_rise) begin
                rx_sr   <= {rx_sr[6:0], mosi};
                bit_cnt <= bit_cnt + 1'b1;
                if (bit_cnt == BIT_CNT_W'(7)) byte_valid <= 1'b1;
            end
        end
    end

    // Purpose: transmit shift register, loaded on request, cleared outside frames.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_sr <= '0;
        end else if (cs_n) begin
            tx_sr <= '0;
        end else if (load_en) begin
            tx_sr <= load_word;
        end else if (sclk_rise) begin
            tx_sr <= {tx_sr[WORD_W-2:0], 1'b0};
        end
    end

endmodule

// File: rtl/cfg_cmd_decoder.sv
// Command decoder. Counts the bytes of each frame and keeps its opcode.
// Assumes byte_valid and frame_end never fall in the same cycle.
// Emits one command pulse when the last command byte arrives, asks for a status
// load on a read-status opcode, and judges program-page frames when cs_n rises.
module cfg_cmd_decoder
    import cfg_resp_pkg::*;
#(
    parameter int CMD_BYTES  = 4,
    parameter int PAGE_BYTES = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       byte_valid,
    input  logic [7:0] byte_data,
    input  logic       frame_end,
    output logic       cmd_valid,
    output cmd_e       cmd,
    output logic       rd_req,
    output logic       page_end,
    output logic       page_ok
);
    localparam int FRAME_BYTES = CMD_BYTES + PAGE_BYTES;
    localparam int CNT_MAX     = FRAME_BYTES + 1;
    localparam int CNT_W       = $clog2(CNT_MAX + 1);

    logic [CNT_W-1:0] byte_cnt;
    logic [7:0]       opcode;
    logic [7:0]       op_now;
    logic             last_cmd_byte;

    assign op_now        = (byte_cnt == '0) ? byte_data : opcode;
    assign last_cmd_byte = byte_valid && (byte_cnt == CNT_W'(CMD_BYTES - 1));

    // Purpose: byte counter that saturates, and capture of the opcode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            byte_cnt <= '0;
            opcode   <= '0;
        end else if (frame_end) begin
            byte_cnt <= '0;
        end else if (byte_valid) begin
            if (byte_cnt == '0) opcode <= byte_data;
            if (byte_cnt != CNT_W'(CNT_MAX)) byte_cnt <= byte_cnt + 1'b1;
        end
    end

    // Purpose: turn the opcode into a command pulse at the last command byte.
    always_comb begin
        cmd_valid = 1'b0;
        cmd       = CMD_NONE;
        rd_req    = 1'b0;
        if (last_cmd_byte) begin
            cmd_valid = 1'b1;
            case (op_now)
                OPC_ENABLE:   cmd = CMD_ENABLE;
                OPC_ERASE:    cmd = CMD_ERASE;
                OPC_INITADDR: cmd = CMD_INIT;
                OPC_PROGDONE: cmd = CMD_PROGDONE;
                OPC_REFRESH:  cmd = CMD_REFRESH;
                OPC_PROGPAGE: cmd = CMD_NONE;
                OPC_RDSTAT: begin
                    cmd    = CMD_NONE;
                    rd_req = 1'b1;
                end
                default:      cmd = CMD_BAD;
            endcase
        end
    end

    // Purpose: judge the length of a program-page frame when the frame closes.
    always_comb begin
        page_end = frame_end && (opcode == OPC_PROGPAGE) && (byte_cnt >= CNT_W'(CMD_BYTES));
        page_ok  = (byte_cnt == CNT_W'(FRAME_BYTES));
    end

endmodule

// File: rtl/cfg_status_engine.sv
// Status engine. Holds the flags, the error code, the busy timer, the page
// counter and the refresh-failure counter, and assembles the 32-bit status word.
// Assumes the busy periods are at least one cycle and that no page frame
// closes in the cycle a busy period ends.
module cfg_status_engine
    import cfg_resp_pkg::*;
#(
    parameter int ERASE_BUSY_CLKS   = 200,
    parameter int DONE_BUSY_CLKS    = 300,
    parameter int REFRESH_ERR_COUNT = 2,
    parameter int PAGE_CNT_W        = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cmd_valid,
    input  cmd_e                  cmd,
    input  logic                  page_end,
    input  logic                  page_ok,
    output logic [STAT_W-1:0]     status_word,
    output logic [PAGE_CNT_W-1:0] page_count
);
    localparam int BUSY_MAX = (ERASE_BUSY_CLKS > DONE_BUSY_CLKS) ? ERASE_BUSY_CLKS : DONE_BUSY_CLKS;
    localparam int BC_W     = $clog2(BUSY_MAX + 1);
    localparam int REF_W    = $clog2(REFRESH_ERR_COUNT + 2);

    flags_t           fl;
    logic [BC_W-1:0]  busy_cnt;
    logic             pd_pending;
    logic [REF_W-1:0] refresh_cnt;

    // Purpose: busy countdown, command effects and page accounting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fl          <= '{busy: 1'b0, fail: 1'b0, enab: 1'b0, done: 1'b0, err: ERR_NONE};
            busy_cnt    <= '0;
            pd_pending  <= 1'b0;
            refresh_cnt <= '0;
            page_count  <= '0;
        end else begin
            if (fl.busy) begin
                busy_cnt <= busy_cnt - 1'b1;
                if (busy_cnt == BC_W'(1)) begin
                    fl.busy <= 1'b0;
                    if (pd_pending) begin
                        pd_pending <= 1'b0;
                        if (page_count != '0) fl.done <= 1'b1;
                        else                  fl.fail <= 1'b1;
                    end
                end
            end
            if (cmd_valid) begin
                case (cmd)
                    CMD_ENABLE: begin
                        fl.enab <= 1'b1;
                        fl.fail <= 1'b0;
                        fl.err  <= ERR_NONE;
                    end
                    CMD_ERASE: begin
                        fl.done    <= 1'b0;
                        fl.busy    <= 1'b1;
                        busy_cnt   <= BC_W'(ERASE_BUSY_CLKS);
                        pd_pending <= 1'b0;
                        page_count <= '0;
                    end
                    CMD_PROGDONE: begin
                        fl.done    <= 1'b0;
                        fl.busy    <= 1'b1;
                        busy_cnt   <= BC_W'(DONE_BUSY_CLKS);
                        pd_pending <= 1'b1;
                    end
                    CMD_REFRESH: begin
                        fl.enab <= 1'b0;
                        if (refresh_cnt < REF_W'(REFRESH_ERR_COUNT)) begin
                            fl.err      <= ERR_CRC;
                            refresh_cnt <= refresh_cnt + 1'b1;
                        end else begin
                            fl.err <= ERR_NONE;
                        end
                    end
                    CMD_BAD:  fl.err <= ERR_CMD;
                    default:  ;
                endcase
            end
            if (page_end) begin
                if (page_ok) page_count <= page_count + 1'b1;
                else         fl.err     <= ERR_OVERFLOW;
            end
        end
    end

    // Purpose: place the flags and the error code at their fixed positions.
    always_comb begin
        status_word                             = '0;
        status_word[BIT_BUSY]                   = fl.busy;
        status_word[BIT_FAIL]                   = fl.fail;
        status_word[BIT_ENAB]                   = fl.enab;
        status_word[BIT_DONE]                   = fl.done;
        status_word[BIT_ERR_LSB+2:BIT_ERR_LSB]  = fl.err;
    end

endmodule

// File: rtl/cfg_target_resp.sv
// Top of the configuration port target responder.
// Joins the SPI shifter, the command decoder and the status engine. A
// read-status frame loads the status word into the shifter after its 4th byte.
module cfg_target_resp
    import cfg_resp_pkg::*;
#(
    parameter int PAGE_BYTES        = 16,
    parameter int ERASE_BUSY_CLKS   = 200,
    parameter int DONE_BUSY_CLKS    = 300,
    parameter int REFRESH_ERR_COUNT = 2,
    parameter int PAGE_CNT_W        = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  sclk,
    input  logic                  cs_n,
    input  logic                  mosi,
    output logic                  miso,
    output logic [PAGE_CNT_W-1:0] page_count
);
    localparam int CMD_BYTES = 4;

    logic              byte_valid;
    logic [7:0]        byte_data;
    logic              frame_end;
    logic              cmd_valid;
    cmd_e              cmd;
    logic              rd_req;
    logic              page_end;
    logic              page_ok;
    logic [STAT_W-1:0] status_word;

    cfg_spi_shifter #(.WORD_W(STAT_W)) u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .sclk       (sclk),
        .cs_n       (cs_n),
        .mosi       (mosi),
        .load_en    (rd_req),
        .load_word  (status_word),
        .byte_valid (byte_valid),
        .byte_data  (byte_data),
        .frame_end  (frame_end),
        .miso       (miso)
    );

    cfg_cmd_decoder #(.CMD_BYTES(CMD_BYTES), .PAGE_BYTES(PAGE_BYTES)) u_dec (
        .clk        (clk),
        .rst_n      (rst_n),
        .byte_valid (byte_valid),
        .byte_data  (byte_data),
        .frame_end  (frame_end),
        .cmd_valid  (cmd_valid),
        .cmd        (cmd),
        .rd_req     (rd_req),
        .page_end   (page_end),
        .page_ok    (page_ok)
    );

    cfg_status_engine #(
        .ERASE_BUSY_CLKS   (ERASE_BUSY_CLKS),
        .DONE_BUSY_CLKS    (DONE_BUSY_CLKS),
        .REFRESH_ERR_COUNT (REFRESH_ERR_COUNT),
        .PAGE_CNT_W        (PAGE_CNT_W)
    ) u_stat (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_valid   (cmd_valid),
        .cmd         (cmd),
        .page_end    (page_end),
        .page_ok     (page_ok),
        .status_word (status_word),
        .page_count  (page_count)
    );

endmodule

// File: rtl/cfg_target_resp_chk.sv
// Checker for the responder: the ordering of busy and done, the page-count
// conditions of program-done, and the size of each page-count step.
module cfg_target_resp_chk #(
    parameter int PAGE_CNT_W = 16
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [31:0]           status_word,
    input logic [PAGE_CNT_W-1:0] page_count
);
    logic busy;
    logic done;
    logic fail;
    assign busy = status_word[12];
    assign done = status_word[8];
    assign fail = status_word[13];

    p_busy_done_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));

    p_done_after_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $fell(busy));

    p_done_has_pages_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> (page_count != '0));

    p_fail_no_pages_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fail) |-> (page_count == '0));

    p_page_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (page_count != $past(page_count)) |->
            ((page_count == $past(page_count) + 1'b1) || (page_count == '0)));

endmodule

bind cfg_target_resp cfg_target_resp_chk #(.PAGE_CNT_W(PAGE_CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .status_word (status_word),
    .page_count  (page_count)
);

// File: tb/cfg_target_resp_tb.sv
// Scoreboard bench: read tasks queue the expected status, and a monitor
// compares each word captured from MISO against the head of the queue.
module cfg_target_resp_tb;
    localparam int HALF   = 2;
    localparam int PCW    = 16;
    localparam int WAIT_B = 400;

    typedef struct {
        logic [31:0] word;
        string       tag;
    } exp_t;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           sclk = 1'b0;
    logic           cs_n = 1'b1;
    logic           mosi = 1'b0;
    logic           miso;
    logic [PCW-1:0] page_count;

    int          checks = 0;
    int          fails  = 0;
    exp_t        sb_q[$];
    logic [31:0] got_word;
    event        got_ev;
    logic [7:0]  frm [0:23];

    always #2 clk = ~clk;

    cfg_target_resp #(
        .PAGE_BYTES(16), .ERASE_BUSY_CLKS(200), .DONE_BUSY_CLKS(300),
        .REFRESH_ERR_COUNT(2), .PAGE_CNT_W(PCW)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n),
        .mosi(mosi), .miso(miso), .page_count(page_count)
    );

    task automatic spi_xfer(input int n, input bit rd, output logic [31:0] word);
        word = '0;
        @(negedge clk) cs_n = 1'b0;
        repeat (2) @(negedge clk);
        for (int b = 0; b < n; b++) begin
            for (int i = 7; i >= 0; i--) begin
                mosi = frm[b][i];
                repeat (HALF) @(negedge clk);
                if (rd && b >= 4) word = {word[30:0], miso};
                sclk = 1'b1;
                repeat (HALF) @(negedge clk);
                sclk = 1'b0;
            end
        end
        repeat (2) @(negedge clk);
        cs_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic cmd_frame(input logic [7:0] op, input int n);
        logic [31:0] dummy;
        frm[0] = op;
        for (int k = 1; k < 24; k++) frm[k] = 8'h00;
        spi_xfer(n, 1'b0, dummy);
    endtask

    task automatic page_frame(input int n, input int seed);
        logic [31:0] dummy;
        frm[0] = 8'h70; frm[1] = 8'h00; frm[2] = 8'h00; frm[3] = 8'h01;
        for (int k = 4; k < 24; k++) frm[k] = 8'(k * 13 + seed);
        spi_xfer(n, 1'b0, dummy);
    endtask

    task automatic rd_status(input logic [31:0] exp_word, input string tag);
        logic [31:0] w;
        exp_t e;
        e.word = exp_word;
        e.tag  = tag;
        sb_q.push_back(e);
        frm[0] = 8'h3C;
        for (int k = 1; k < 24; k++) frm[k] = 8'hA5;
        spi_xfer(8, 1'b1, w);
        got_word = w;
        -> got_ev;
    endtask

    task automatic chk_pages(input logic [PCW-1:0] exp_p, input string tag);
        @(negedge clk);
        checks++;
        if (page_count !== exp_p) begin
            fails++;
            $display("FAIL %s page_count actual=%0d expected=%0d", tag, page_count, exp_p);
        end
    endtask

    // Monitor: compares every captured status word with the oldest expected one.
    initial begin
        forever begin
            @(got_ev);
            checks++;
            if (sb_q.size() == 0) begin
                fails++;
                $display("FAIL R2 unexpected status word actual=%08h expected=none", got_word);
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                if (got_word !== e.word) begin
                    fails++;
                    $display("FAIL %s status actual=%08h expected=%08h", e.tag, got_word, e.word);
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reaches the summary.
    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        chk_pages(16'd0, "R2 reset");
        rd_status(32'h0000_0000, "R2 reset status");

        cmd_frame(8'hC6, 4);
        rd_status(32'h0000_0200, "R3 enable");

        cmd_frame(8'h0E, 4);
        rd_status(32'h0000_1200, "R4 erase busy, R9");
        repeat (WAIT_B) @(negedge clk);
        rd_status(32'h0000_0200, "R4 erase over");

        cmd_frame(8'h5E, 4);
        rd_status(32'h0000_1200, "R6 progdone busy");
        repeat (WAIT_B) @(negedge clk);
        rd_status(32'h0000_2200, "R6 no pages gives fail");

        cmd_frame(8'hC6, 4);
        rd_status(32'h0000_0200, "R3 enable clears fail");

        cmd_frame(8'h46, 4);
        rd_status(32'h0000_0200, "R7 init-address no change");

        page_frame(20, 1);
        page_frame(20, 2);
        page_frame(20, 3);
        chk_pages(16'd3, "R5 three pages");
        rd_status(32'h0000_0200, "R5 good pages no error");

        page_frame(19, 4);
        rd_status(32'h0300_0200, "R5 short page overflow");
        chk_pages(16'd3, "R5 short page not counted");

        cmd_frame(8'hC6, 4);
        rd_status(32'h0000_0200, "R3 enable clears error");

        cmd_frame(8'hAB, 4);
        rd_status(32'h0100_0200, "R7 unknown opcode");

        cmd_frame(8'h0E, 2);
        rd_status(32'h0100_0200, "R1 short frame ignored");
        chk_pages(16'd3, "R1 short frame keeps pages");

        cmd_frame(8'hC6, 4);
        cmd_frame(8'h5E, 4);
        rd_status(32'h0000_1200, "R9 progdone busy without done");
        repeat (WAIT_B) @(negedge clk);
        rd_status(32'h0000_0300, "R6 done with pages");

        cmd_frame(8'h79, 4);
        rd_status(32'h0180_0100, "R8 refresh 1 error");
        cmd_frame(8'h79, 4);
        rd_status(32'h0180_0100, "R8 refresh 2 error");
        cmd_frame(8'h79, 4);
        rd_status(32'h0000_0100, "R8 refresh 3 clean");

        cmd_frame(8'h0E, 4);
        rd_status(32'h0000_1000, "R4 erase clears done");
        chk_pages(16'd0, "R4 erase clears pages");
        repeat (WAIT_B) @(negedge clk);
        rd_status(32'h0000_0000, "R4 idle after erase");

        repeat (4) @(negedge clk);
        checks++;
        if (sb_q.size() != 0) begin
            fails++;
            $display("FAIL R2 pending reads actual=%0d expected=0", sb_q.size());
        end
        $display("  test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end

endmodule